// File: doc/BRIEF.md
# Function Configuration Header with Base-Address Slots

This block is the configuration register file of one peripheral function. It is laid out as a type-0 configuration header and is reached through a plain 32-bit register port. The port carries a byte address, a write strobe, four byte enables and write data. Read data is combinational from the address. The header returns fixed identity words that are set by parameters. It holds one writable command register, where only a chosen set of bits can change, and a read-only status half-word.

Six base-address slots follow the identity words. Parameters bind up to six address windows to these slots, starting after a chosen number of reserved leading slots. A 32-bit window uses one slot. A 64-bit window uses two adjacent slots, and the second of the two carries address bits 63:32. Each window has its own size and type: I/O or memory, 32- or 64-bit, prefetchable or not.

A base written through the lower slot is forced onto a multiple of the window size. The window's type flags are merged into the value read back from that slot. Slots that no window claims read as zero and discard writes. Each write that lands on a claimed slot raises a one-cycle refresh pulse, so that address decoders downstream can reload their windows.

Top module: `cfg_hdr_regs`

## Requirements
- R1: Offset 0x00 reads {device id, vendor id}. Offset 0x08 reads {class code[23:0], revision}. Offset 0x0C reads, from bit 31 down, {BIST, header type, latency timer, cache line size}. Offset 0x2C reads {subsystem id, subsystem vendor id}. Offset 0x34 reads the capability pointer in bits 7:0 and zero elsewhere. Writes to any of these words change nothing that is read back.
- R2: Offset 0x04 reads {status, command}. After reset the command is 0x0080 and the status is the STATUS_VAL parameter (0x0000 by default).
- R3: A write to 0x04 changes only the command bits that are both set in mask 0x01BF and covered by an asserted byte enable (be[0] covers bits 7:0, be[1] covers bits 15:8). Every other command bit keeps its value.
- R4: A write to the lower (or only) slot of a window merges the enabled bytes into the stored low address word. It then clears every bit below log2(window size) and keeps the high half.
- R5: A read of a lower slot returns the stored low address ORed with the type flags: bit 0 for an I/O window, bit 2 for a 64-bit window, bit 3 for a prefetchable window.
- R6: The slot that follows the lower slot of a 64-bit window reads and writes address bits 63:32 with no size masking. A write to the lower slot leaves this value unchanged.
- R7: Slots that are reserved or claimed by no window read as zero and ignore writes.
- R8: Reset clears every window address to zero, both low and high halves.
- R9: Offsets with no defined field (0x28, 0x30, and 0x38 and above) read as zero.
- R10: `bar_wr_pulse` is high for exactly the one cycle that follows each clock edge at which a write to a claimed slot is taken. It stays low after writes anywhere else.
- R11: Byte enables act per byte on window addresses: be[k] covers bits 8k+7:8k, in both the lower and the upper slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, deasserts in step with clk |
| reg_addr | input | ADDR_W | Byte address of the dword accessed; bits 1:0 are ignored |
| reg_we | input | 1 | Write strobe, taken at the rising clock edge |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| bar_wr_pulse | output | 1 | One-cycle pulse after a write to a claimed base slot |

## Verification
A base write and the refresh pulse that reports it fall in the same cycle. In that cycle the new, size-aligned address is already readable and the pulse is high. The overlap is provoked with back-to-back writes to two different windows, so that the pulse of the first write runs straight into the pulse of the second. The bench judges the result by sampling in the cycle after the second write. There it expects the pulse still high and the second window already reading its aligned address with its I/O flag set. One cycle later it expects the pulse low.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NSLOT      = 6;   // base-address slots in the header
  localparam int SLOT_DW0   = 4;   // dword index of the first slot (0x10)

  localparam int DW_IDENT   = 0;
  localparam int DW_CMDSTS  = 1;
  localparam int DW_CLASS   = 2;
  localparam int DW_MISC    = 3;
  localparam int DW_SUBSYS  = 11;
  localparam int DW_CAPPTR  = 13;

  // First slot taken by window w, given reserved slots and 64-bit flags.
  function automatic int win_first_slot(int w, int skip, logic [NSLOT-1:0] w64);
    int s;
    s = skip;
    for (int j = 0; j < NSLOT; j++)
      if (j < w) s += w64[j] ? 2 : 1;
    return s;
  endfunction

  function automatic bit win_fits(int w, int skip, int nwin, logic [NSLOT-1:0] w64);
    int first;
    first = win_first_slot(w, skip, w64);
    return (w < nwin) && ((first + (w64[w] ? 1 : 0)) < NSLOT);
  endfunction

  // Window that owns a slot, or -1 when the slot is free.
  function automatic int slot_owner(int slot, int skip, int nwin, logic [NSLOT-1:0] w64);
    int r;
    int first;
    r = -1;
    for (int j = 0; j < NSLOT; j++) begin
      first = win_first_slot(j, skip, w64);
      if (win_fits(j, skip, nwin, w64)) begin
        if (first == slot) r = j;
        if (w64[j] && (first + 1 == slot)) r = j;
      end
    end
    return r;
  endfunction

  // True when the slot is the high half of a 64-bit window.
  function automatic bit slot_upper(int slot, int skip, int nwin, logic [NSLOT-1:0] w64);
    bit r;
    r = 1'b0;
    for (int j = 0; j < NSLOT; j++)
      if (win_fits(j, skip, nwin, w64) && w64[j] &&
          (win_first_slot(j, skip, w64) + 1 == slot))
        r = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg #(
  parameter logic [15:0] RST_VAL = 16'h0080,
  parameter logic [15:0] WR_MASK = 16'h01BF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] q
);

  logic [15:0] bit_en;
  logic [15:0] q_nxt;

  always_comb begin
    bit_en = {{8{be[1]}}, {8{be[0]}}} & WR_MASK;
    q_nxt  = (q & ~bit_en) | (wdata & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= q_nxt;
  end

endmodule

// File: rtl/cfg_bar_win.sv
module cfg_bar_win #(
  parameter int SIZE_LOG2 = 12,   // at least 4 so flags never overlap address
  parameter bit IS64      = 1'b0,
  parameter bit IS_IO     = 1'b0,
  parameter bit IS_PREF   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);

  localparam logic [63:0] SPAN  = 64'd1 << SIZE_LOG2;
  localparam logic [31:0] ALIGN = 32'(~(SPAN - 64'd1));
  localparam logic [3:0]  FLAGS = {IS_PREF, IS64, 1'b0, IS_IO};

  logic [31:0] byte_en;
  logic [31:0] lo_q, lo_nxt;

  always_comb begin
    byte_en = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    lo_nxt  = ((lo_q & ~byte_en) | (wdata & byte_en)) & ALIGN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (wr_lo) lo_q <= lo_nxt;
  end

  assign rd_lo = lo_q | {28'd0, FLAGS};

  if (IS64) begin : g_hi
    logic [31:0] hi_q, hi_nxt;
    always_comb hi_nxt = (hi_q & ~byte_en) | (wdata & byte_en);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (wr_hi) hi_q <= hi_nxt;
    end
    assign rd_hi = hi_q;
  end else begin : g_no_hi
    logic unused_wr_hi;
    assign unused_wr_hi = wr_hi;
    assign rd_hi = '0;
  end

endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] VENDOR_ID  = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID  = 16'h0C31,
  parameter logic [23:0] CLASS_CODE = 24'h0C0500,
  parameter logic [7:0]  REVISION   = 8'h02,
  parameter logic [7:0]  CACHE_LINE = 8'h10,
  parameter logic [7:0]  LAT_TIMER  = 8'h20,
  parameter logic [7:0]  HDR_TYPE   = 8'h00,
  parameter logic [7:0]  BIST_VAL   = 8'h00,
  parameter logic [15:0] SUB_VENDOR = 16'h1D5A,
  parameter logic [15:0] SUB_ID     = 16'h0001,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter logic [15:0] STATUS_VAL = 16'h0000,
  parameter logic [15:0] CMD_RESET  = 16'h0080,
  parameter logic [15:0] CMD_MASK   = 16'h01BF,
  parameter int          SKIP_SLOTS = 1,
  parameter int          NUM_WIN    = 3,
  // Per window w: size log2 in [6w+:6], flags in bit w
  parameter logic [6*NSLOT-1:0] WIN_LOG2 = {6'd0, 6'd0, 6'd0, 6'd5, 6'd20, 6'd12},
  parameter logic [NSLOT-1:0]   WIN_64   = 6'b000010,
  parameter logic [NSLOT-1:0]   WIN_IO   = 6'b000100,
  parameter logic [NSLOT-1:0]   WIN_PREF = 6'b000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              bar_wr_pulse
);

  localparam int DW_W = ADDR_W - 2;

  logic [DW_W-1:0] dw;
  logic            unused_lsb;
  assign dw         = reg_addr[ADDR_W-1:2];
  assign unused_lsb = ^reg_addr[1:0];

  // Command register
  logic [15:0] cmd_q;
  logic        cmd_we;
  assign cmd_we = reg_we && (dw == DW_W'(DW_CMDSTS));

  cfg_cmd_reg #(.RST_VAL(CMD_RESET), .WR_MASK(CMD_MASK)) u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cmd_we),
    .be    (reg_be[1:0]),
    .wdata (reg_wdata[15:0]),
    .q     (cmd_q)
  );

  // Address windows
  logic [31:0] win_lo [NSLOT];
  logic [31:0] win_hi [NSLOT];

  for (genvar gw = 0; gw < NSLOT; gw++) begin : g_win
    localparam int FIRST = win_first_slot(gw, SKIP_SLOTS, WIN_64);
    if (win_fits(gw, SKIP_SLOTS, NUM_WIN, WIN_64)) begin : g_on
      logic wr_lo, wr_hi;
      assign wr_lo = reg_we && (dw == DW_W'(SLOT_DW0 + FIRST));
      assign wr_hi = reg_we && WIN_64[gw] && (dw == DW_W'(SLOT_DW0 + FIRST + 1));
      cfg_bar_win #(
        .SIZE_LOG2 (int'(WIN_LOG2[6*gw +: 6])),
        .IS64      (WIN_64[gw]),
        .IS_IO     (WIN_IO[gw]),
        .IS_PREF   (WIN_PREF[gw])
      ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .be    (reg_be),
        .wdata (reg_wdata),
        .rd_lo (win_lo[gw]),
        .rd_hi (win_hi[gw])
      );
    end else begin : g_off
      assign win_lo[gw] = '0;
      assign win_hi[gw] = '0;
    end
  end

  // Slot to window linkage
  logic [31:0]      slot_rd [NSLOT];
  logic [NSLOT-1:0] slot_linked;

  for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
    localparam int OWN = slot_owner(gs, SKIP_SLOTS, NUM_WIN, WIN_64);
    localparam bit UP  = slot_upper(gs, SKIP_SLOTS, NUM_WIN, WIN_64);
    if (OWN < 0) begin : g_free
      assign slot_rd[gs]     = '0;
      assign slot_linked[gs] = 1'b0;
    end else if (UP) begin : g_upper
      assign slot_rd[gs]     = win_hi[OWN];
      assign slot_linked[gs] = 1'b1;
    end else begin : g_lower
      assign slot_rd[gs]     = win_lo[OWN];
      assign slot_linked[gs] = 1'b1;
    end
  end

  logic       in_slots;
  logic [2:0] sidx;
  assign in_slots = (dw >= DW_W'(SLOT_DW0)) && (dw < DW_W'(SLOT_DW0 + NSLOT));
  assign sidx     = 3'(dw - DW_W'(SLOT_DW0));

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (in_slots) begin
      reg_rdata = slot_rd[sidx];
    end else begin
      case (dw)
        DW_W'(DW_IDENT):  reg_rdata = {DEVICE_ID, VENDOR_ID};
        DW_W'(DW_CMDSTS): reg_rdata = {STATUS_VAL, cmd_q};
        DW_W'(DW_CLASS):  reg_rdata = {CLASS_CODE, REVISION};
        DW_W'(DW_MISC):   reg_rdata = {BIST_VAL, HDR_TYPE, LAT_TIMER, CACHE_LINE};
        DW_W'(DW_SUBSYS): reg_rdata = {SUB_ID, SUB_VENDOR};
        DW_W'(DW_CAPPTR): reg_rdata = {24'd0, CAP_PTR};
        default:          reg_rdata = '0;
      endcase
    end
  end

  // Refresh pulse
  logic pulse_nxt, pulse_q;
  always_comb pulse_nxt = reg_we && in_slots && slot_linked[sidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_nxt;
  end

  assign bar_wr_pulse = pulse_q;

endmodule

// File: rtl/cfg_hdr_sva.sv
module cfg_hdr_sva #(
  parameter int          ADDR_W    = 8,
  parameter logic [15:0] CMD_MASK  = 16'h01BF,
  parameter logic [15:0] VENDOR_ID = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID = 16'h0C31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_rdata,
  input logic              bar_wr_pulse,
  input logic [15:0]       cmd_q
);

  AST_CMD_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cmd_q & ~CMD_MASK));                                          // R3

  AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_pulse |-> $past(reg_we));                                      // R10

  AST_PULSE_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_pulse |-> ($past(reg_addr[ADDR_W-1:2]) >= (ADDR_W-2)'(4) &&
                      $past(reg_addr[ADDR_W-1:2]) <= (ADDR_W-2)'(9)));    // R10

  AST_IDENT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] == '0) |-> (reg_rdata == {DEVICE_ID, VENDOR_ID})); // R1

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[ADDR_W-1:2] > (ADDR_W-2)'(13)) |-> (reg_rdata == '0));       // R9

endmodule

bind cfg_hdr_regs cfg_hdr_sva #(
  .ADDR_W    (ADDR_W),
  .CMD_MASK  (CMD_MASK),
  .VENDOR_ID (VENDOR_ID),
  .DEVICE_ID (DEVICE_ID)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_we       (reg_we),
  .reg_rdata    (reg_rdata),
  .bar_wr_pulse (bar_wr_pulse),
  .cmd_q        (cmd_q)
);

// File: tb/cfg_hdr_regs_bench.sv
`timescale 1ns/1ps
module cfg_hdr_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        bar_wr_pulse;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cfg_hdr_regs u_cfg_hdr_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_be       (reg_be),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .bar_wr_pulse (bar_wr_pulse)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 34;
  // Default map: slot 0x10 reserved, 0x14 mem32 4 KiB, 0x18/0x1C mem64 prefetchable 1 MiB,
  // 0x20 I/O 32 bytes, 0x24 free.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 4'h0, 32'h0,        32'h0C311D5A, 4'd1},  // R1
    '{1'b0, 8'h04, 4'h0, 32'h0,        32'h00000080, 4'd2},  // R2
    '{1'b0, 8'h08, 4'h0, 32'h0,        32'h0C050002, 4'd1},  // R1
    '{1'b0, 8'h0C, 4'h0, 32'h0,        32'h00002010, 4'd1},  // R1
    '{1'b0, 8'h2C, 4'h0, 32'h0,        32'h00011D5A, 4'd1},  // R1
    '{1'b0, 8'h34, 4'h0, 32'h0,        32'h00000040, 4'd1},  // R1
    '{1'b0, 8'h10, 4'h0, 32'h0,        32'h00000000, 4'd7},  // R7
    '{1'b0, 8'h14, 4'h0, 32'h0,        32'h00000000, 4'd8},  // R8
    '{1'b0, 8'h18, 4'h0, 32'h0,        32'h0000000C, 4'd8},  // R8 R5
    '{1'b0, 8'h1C, 4'h0, 32'h0,        32'h00000000, 4'd8},  // R8
    '{1'b0, 8'h20, 4'h0, 32'h0,        32'h00000001, 4'd5},  // R5
    '{1'b0, 8'h24, 4'h0, 32'h0,        32'h00000000, 4'd7},  // R7
    '{1'b1, 8'h04, 4'hF, 32'hFFFFFFFF, 32'h000001BF, 4'd3},  // R3
    '{1'b1, 8'h04, 4'h1, 32'h00000000, 32'h00000100, 4'd3},  // R3
    '{1'b1, 8'h04, 4'h2, 32'h00000000, 32'h00000000, 4'd3},  // R3
    '{1'b1, 8'h14, 4'hF, 32'hFFFFFFFF, 32'hFFFFF000, 4'd4},  // R4
    '{1'b1, 8'h14, 4'h3, 32'h12345678, 32'hFFFF5000, 4'd11}, // R11
    '{1'b1, 8'h14, 4'h8, 32'h00000000, 32'h00FF5000, 4'd11}, // R11
    '{1'b1, 8'h18, 4'hF, 32'hFFFFFFFF, 32'hFFF0000C, 4'd4},  // R4 R5
    '{1'b1, 8'h1C, 4'hF, 32'hDEADBEEF, 32'hDEADBEEF, 4'd6},  // R6
    '{1'b1, 8'h18, 4'hF, 32'h00A55FFF, 32'h00A0000C, 4'd4},  // R4
    '{1'b0, 8'h1C, 4'h0, 32'h0,        32'hDEADBEEF, 4'd6},  // R6
    '{1'b1, 8'h1C, 4'h4, 32'h00000000, 32'hDE00BEEF, 4'd11}, // R11
    '{1'b1, 8'h20, 4'hF, 32'hFFFFFFFF, 32'hFFFFFFE1, 4'd4},  // R4
    '{1'b1, 8'h20, 4'h1, 32'h0000003F, 32'hFFFFFF21, 4'd4},  // R4
    '{1'b1, 8'h10, 4'hF, 32'hFFFFFFFF, 32'h00000000, 4'd7},  // R7
    '{1'b1, 8'h24, 4'hF, 32'hFFFFFFFF, 32'h00000000, 4'd7},  // R7
    '{1'b1, 8'h00, 4'hF, 32'hFFFFFFFF, 32'h0C311D5A, 4'd1},  // R1
    '{1'b1, 8'h08, 4'hF, 32'h00000000, 32'h0C050002, 4'd1},  // R1
    '{1'b0, 8'h28, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b0, 8'h30, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b0, 8'h38, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b0, 8'hFC, 4'h0, 32'h0,        32'h00000000, 4'd9},  // R9
    '{1'b1, 8'h34, 4'hF, 32'hFFFFFFFF, 32'h00000040, 4'd1}   // R1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_be = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pulse low after reset", {31'd0, bar_wr_pulse}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) write(VECS[i].addr, VECS[i].be, VECS[i].wd);
      else @(negedge clk);
      read_chk($sformatf("R%0d vector %0d addr %02h", VECS[i].req, i, VECS[i].addr),
               VECS[i].addr, VECS[i].exp);
    end

    // R10: single write to a linked slot
    write(8'h14, 4'hF, 32'h00000000);
    check("R10 pulse after base write", {31'd0, bar_wr_pulse}, 32'd1);
    @(negedge clk);
    check("R10 pulse lasts one cycle", {31'd0, bar_wr_pulse}, 32'd0);

    // R10 with R4/R5: back-to-back writes to two windows
    @(negedge clk);
    reg_addr = 8'h14; reg_be = 4'hF; reg_wdata = 32'h00003000; reg_we = 1'b1;
    @(negedge clk);
    check("R10 pulse after first of pair", {31'd0, bar_wr_pulse}, 32'd1);
    reg_addr = 8'h20; reg_wdata = 32'h0000004F;
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 pulse held by second write", {31'd0, bar_wr_pulse}, 32'd1);
    read_chk("R4 second window aligned in pulse cycle", 8'h20, 32'h00000041);
    read_chk("R4 first window of pair", 8'h14, 32'h00003000);
    @(negedge clk);
    check("R10 pulse drops after pair", {31'd0, bar_wr_pulse}, 32'd0);

    // R10: writes elsewhere raise no pulse; upper slot does
    write(8'h10, 4'hF, 32'hFFFFFFFF);
    check("R10 no pulse for reserved slot", {31'd0, bar_wr_pulse}, 32'd0);
    write(8'h04, 4'hF, 32'h00000001);
    check("R10 no pulse for command write", {31'd0, bar_wr_pulse}, 32'd0);
    write(8'h1C, 4'hF, 32'h00000005);
    check("R10 pulse for upper slot", {31'd0, bar_wr_pulse}, 32'd1);

    // R8 / R2: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    read_chk("R8 lower slot cleared by reset", 8'h18, 32'h0000000C);
    read_chk("R8 upper slot cleared by reset", 8'h1C, 32'h00000000);
    read_chk("R8 mem32 window cleared by reset", 8'h14, 32'h00000000);
    read_chk("R2 command back to reset value", 8'h04, 32'h00000080);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pulse low after second reset", {31'd0, bar_wr_pulse}, 32'd0);

    finish_run();
  end

endmodule